// File: doc/BRIEF.md
# Triggered Test-Pattern Event Transmitter

This block holds a set of test events in an on-chip pattern memory. It plays one of them out as a framed link packet each time a level-1 accept arrives. A host loads the memory and a small bank of control registers through a plain address, data and write-enable port. Each accept carries a buffer number. The accept is queued, and after a programmable start delay the sequencer emits four kinds of word:

- a first header word;
- a second header word carrying the latency setting and the payload size;
- the payload read from memory, optionally spaced by idle cycles;
- a trailer carrying the size again and the error flags.

The output is a 32-bit word stream with a valid strobe, intended to feed an output FIFO. The FIFO's full flag holds the sequencer in place.

Each stored event is described by a start address and a length. A length of zero gives an empty event, which has framing but no payload. A mode register picks the event to play. The mode also chooses whether every accept replays that one event or steps through the descriptors in turn.

Top module: `tpx_event_tx`

## Requirements
- R1: After reset `out_valid` is low, and no word is emitted until an accept is received.
- R2: A packet has this word layout, with words in this order:
  - First header: `{8'hE5, event index[7:0], 8'h00, buffer number[7:0]}`.
  - Second header: `{start delay[15:0], length[15:0]}`.
  - Payload: `length` words read from memory, starting at the event's start address.
  - Trailer: `{length[15:0], 15'b0, drop flag}`.
- R3: The first header word is visible in the cycle D+2 clock edges after the edge that samples the accept, where D is the programmed start delay. This holds when the accept queue is empty and the sequencer is idle.
- R4: With gap setting G, consecutive payload words of one event appear G+1 cycles apart.
- R5: An event whose length register is zero is sent as exactly three words: two headers and a trailer, both carrying size 0.
- R6: With mode bit 0 clear, every accept plays the event selected by mode bits [15:8].
- R7: With mode bit 0 set, playback starts at the selected event and advances by one descriptor after each packet, wrapping from the last descriptor to descriptor 0.
- R8: Accepts that arrive while a packet is pending are queued with their buffer numbers and are played in arrival order.
- R9: An accept that arrives while QDEPTH accepts are already waiting is dropped. The trailer of the next packet completed sets its drop flag (bit 0), and the flag is then cleared.
- R10: If `out_full` is high at a clock edge, `out_valid` is low after that edge. The stream resumes with no word lost or repeated.
- R11: Payload addresses wrap modulo the memory depth.
- R12: Host writes decode as follows:
  - With `host_addr[10]` = 0, the write goes to the memory word at `host_addr[9:0]`.
  - With `host_addr[10]` = 1, `host_addr[7:0]` selects a register: 0 is the start delay, 1 is the gap, 2 is the mode, 16+e is the start address of event e, and 32+e is the length of event e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W+1 | Host address: memory or register space |
| host_wdata | input | 32 | Host write data |
| acc_valid | input | 1 | Level-1 accept pulse |
| acc_buf | input | BUF_W | Buffer number of the accept |
| out_full | input | 1 | Downstream FIFO full |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |

## Verification
The hardest situation to reach is a queue overflow whose drop flag must land on exactly one trailer. To reach it, the bench programs a long start delay and issues one accept, which the sequencer takes at once. It then fires five more accepts while the first event is still counting down. Four of these fill the queue and the fifth is dropped, so only the first trailer shows the flag. Back-pressure is tested separately: the bench asserts full on two of every three cycles across whole packets, and every header, payload and trailer word is compared afterwards.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DELAY,
        S_HDR1,
        S_HDR2,
        S_DATA,
        S_GAP,
        S_TRAIL
    } tpx_state_e;

    localparam int REG_DELAY      = 0;
    localparam int REG_GAP        = 1;
    localparam int REG_MODE       = 2;
    localparam int REG_START_BASE = 16;
    localparam int REG_LEN_BASE   = 32;
    localparam int LEN_W          = 16;

endpackage

// File: rtl/tpx_acc_queue.sv
module tpx_acc_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          drop,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_q, q_d;
    logic do_push, do_pop;

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign head  = q_q.slot[q_q.rd];
    assign count = q_q.cnt;
    assign drop  = push && full;

    always_comb begin
        q_d     = q_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            q_d.slot[q_q.wr] = push_data;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

endmodule

// File: rtl/tpx_host_cfg.sv
module tpx_host_cfg import tpx_pkg::*; #(
    parameter int ADDR_W = 10,
    parameter int NEVT   = 4,
    parameter int DLY_W  = 24,
    parameter int GAP_W  = 8,
    localparam int EVT_W = (NEVT > 1) ? $clog2(NEVT) : 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [ADDR_W:0]               host_addr,
    input  logic [31:0]                   host_wdata,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [31:0]                   rd_data,
    output logic [DLY_W-1:0]              cfg_delay,
    output logic [GAP_W-1:0]              cfg_gap,
    output logic                          cfg_step,
    output logic [EVT_W-1:0]              cfg_sel,
    output logic                          cfg_sel_load,
    output logic [NEVT-1:0][ADDR_W-1:0]   evt_start,
    output logic [NEVT-1:0][LEN_W-1:0]    evt_len
);

    typedef struct packed {
        logic [DLY_W-1:0]            delay;
        logic [GAP_W-1:0]            gap;
        logic                        step;
        logic [EVT_W-1:0]            sel;
        logic                        sel_load;
        logic [NEVT-1:0][ADDR_W-1:0] start;
        logic [NEVT-1:0][LEN_W-1:0]  len;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic [31:0] mem [DEPTH];
    logic        reg_we, ram_we;
    logic [7:0]  idx;

    assign reg_we = host_we && host_addr[ADDR_W];
    assign ram_we = host_we && !host_addr[ADDR_W];
    assign idx    = host_addr[7:0];

    always_comb begin
        cfg_d          = cfg_q;
        cfg_d.sel_load = 1'b0;
        if (reg_we) begin
            if (idx == 8'(REG_DELAY)) cfg_d.delay = host_wdata[DLY_W-1:0];
            if (idx == 8'(REG_GAP))   cfg_d.gap   = host_wdata[GAP_W-1:0];
            if (idx == 8'(REG_MODE)) begin
                cfg_d.step     = host_wdata[0];
                cfg_d.sel      = host_wdata[8 +: EVT_W];
                cfg_d.sel_load = 1'b1;
            end
            for (int e = 0; e < NEVT; e++) begin
                if (idx == 8'(REG_START_BASE + e)) cfg_d.start[e] = host_wdata[ADDR_W-1:0];
                if (idx == 8'(REG_LEN_BASE + e))   cfg_d.len[e]   = host_wdata[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_ff @(posedge clk) begin
        if (ram_we) mem[host_addr[ADDR_W-1:0]] <= host_wdata;
    end

    assign rd_data      = mem[rd_addr];
    assign cfg_delay    = cfg_q.delay;
    assign cfg_gap      = cfg_q.gap;
    assign cfg_step     = cfg_q.step;
    assign cfg_sel      = cfg_q.sel;
    assign cfg_sel_load = cfg_q.sel_load;
    assign evt_start    = cfg_q.start;
    assign evt_len      = cfg_q.len;

endmodule

// File: rtl/tpx_sequencer.sv
module tpx_sequencer import tpx_pkg::*; #(
    parameter int ADDR_W        = 10,
    parameter int NEVT          = 4,
    parameter int DLY_W         = 24,
    parameter int GAP_W         = 8,
    parameter int BUF_W         = 8,
    parameter logic [7:0] FMT_TAG = 8'hE5,
    localparam int EVT_W        = (NEVT > 1) ? $clog2(NEVT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DLY_W-1:0]             cfg_delay,
    input  logic [GAP_W-1:0]             cfg_gap,
    input  logic                         cfg_step,
    input  logic [EVT_W-1:0]             cfg_sel,
    input  logic                         cfg_sel_load,
    input  logic [NEVT-1:0][ADDR_W-1:0]  evt_start,
    input  logic [NEVT-1:0][LEN_W-1:0]   evt_len,
    input  logic                         q_empty,
    input  logic [BUF_W-1:0]             q_head,
    output logic                         q_pop,
    input  logic                         q_drop,
    output logic [ADDR_W-1:0]            rd_addr,
    input  logic [31:0]                  rd_data,
    input  logic                         out_full,
    output logic                         out_valid,
    output logic [31:0]                  out_data,
    output logic                         busy,
    output logic                         in_gap,
    output logic                         ovf_pending
);

    typedef struct packed {
        tpx_state_e        state;
        logic [DLY_W-1:0]  cnt;
        logic [BUF_W-1:0]  bufn;
        logic [EVT_W-1:0]  evt;
        logic [EVT_W-1:0]  ptr;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic              ovf;
        logic              ovalid;
        logic [31:0]       odata;
    } seq_t;

    seq_t s_q, s_d;
    logic trailer_emit;

    always_comb begin
        s_d          = s_q;
        s_d.ovalid   = 1'b0;
        q_pop        = 1'b0;
        trailer_emit = 1'b0;
        rd_addr      = s_q.base + s_q.idx[ADDR_W-1:0];

        case (s_q.state)
            S_IDLE: begin
                if (!q_empty) begin
                    q_pop     = 1'b1;
                    s_d.bufn  = q_head;
                    s_d.evt   = s_q.ptr;
                    s_d.base  = evt_start[s_q.ptr];
                    s_d.len   = evt_len[s_q.ptr];
                    s_d.idx   = '0;
                    s_d.cnt   = cfg_delay;
                    s_d.state = (cfg_delay == '0) ? S_HDR1 : S_DELAY;
                end
            end
            S_DELAY: begin
                if (s_q.cnt <= DLY_W'(1)) s_d.state = S_HDR1;
                else                      s_d.cnt   = s_q.cnt - 1'b1;
            end
            S_HDR1: begin
                if (!out_full) begin
                    s_d.ovalid = 1'b1;
                    s_d.odata  = {FMT_TAG, 8'(s_q.evt), 8'h00, 8'(s_q.bufn)};
                    s_d.state  = S_HDR2;
                end
            end
            S_HDR2: begin
                if (!out_full) begin
                    s_d.ovalid = 1'b1;
                    s_d.odata  = {16'(cfg_delay), s_q.len};
                    s_d.state  = (s_q.len == '0) ? S_TRAIL : S_DATA;
                end
            end
            S_DATA: begin
                if (!out_full) begin
                    s_d.ovalid = 1'b1;
                    s_d.odata  = rd_data;
                    s_d.idx    = s_q.idx + 1'b1;
                    if (s_q.idx + 1'b1 == s_q.len) begin
                        s_d.state = S_TRAIL;
                    end else if (cfg_gap != '0) begin
                        s_d.state = S_GAP;
                        s_d.cnt   = DLY_W'(cfg_gap);
                    end
                end
            end
            S_GAP: begin
                if (s_q.cnt <= DLY_W'(1)) s_d.state = S_DATA;
                else                      s_d.cnt   = s_q.cnt - 1'b1;
            end
            S_TRAIL: begin
                if (!out_full) begin
                    s_d.ovalid   = 1'b1;
                    s_d.odata    = {s_q.len, 15'b0, s_q.ovf};
                    s_d.state    = S_IDLE;
                    trailer_emit = 1'b1;
                end
            end
            default: s_d.state = S_IDLE;
        endcase

        if (trailer_emit) s_d.ovf = q_drop;
        else              s_d.ovf = s_q.ovf | q_drop;

        if (cfg_sel_load) begin
            s_d.ptr = cfg_sel;
        end else if (trailer_emit && cfg_step) begin
            s_d.ptr = (s_q.ptr == EVT_W'(NEVT - 1)) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid   = s_q.ovalid;
    assign out_data    = s_q.odata;
    assign busy        = (s_q.state != S_IDLE);
    assign in_gap      = (s_q.state == S_GAP);
    assign ovf_pending = s_q.ovf;

endmodule

// File: rtl/tpx_event_tx.sv
module tpx_event_tx import tpx_pkg::*; #(
    parameter int ADDR_W          = 10,
    parameter int NEVT            = 4,
    parameter int DLY_W           = 24,
    parameter int GAP_W           = 8,
    parameter int BUF_W           = 8,
    parameter int QDEPTH          = 4,
    parameter logic [7:0] FMT_TAG = 8'hE5,
    localparam int EVT_W          = (NEVT > 1) ? $clog2(NEVT) : 1,
    localparam int QCW            = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W:0]   host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              acc_valid,
    input  logic [BUF_W-1:0]  acc_buf,
    input  logic              out_full,
    output logic              out_valid,
    output logic [31:0]       out_data
);

    logic [ADDR_W-1:0]           rd_addr;
    logic [31:0]                 rd_data;
    logic [DLY_W-1:0]            cfg_delay;
    logic [GAP_W-1:0]            cfg_gap;
    logic                        cfg_step;
    logic [EVT_W-1:0]            cfg_sel;
    logic                        cfg_sel_load;
    logic [NEVT-1:0][ADDR_W-1:0] evt_start;
    logic [NEVT-1:0][LEN_W-1:0]  evt_len;
    logic                        q_pop, q_empty, q_full, q_drop;
    logic [BUF_W-1:0]            q_head;
    logic [QCW-1:0]              q_cnt;
    logic                        seq_busy, seq_in_gap, ovf_flag;

    tpx_host_cfg #(
        .ADDR_W (ADDR_W),
        .NEVT   (NEVT),
        .DLY_W  (DLY_W),
        .GAP_W  (GAP_W)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cfg_delay    (cfg_delay),
        .cfg_gap      (cfg_gap),
        .cfg_step     (cfg_step),
        .cfg_sel      (cfg_sel),
        .cfg_sel_load (cfg_sel_load),
        .evt_start    (evt_start),
        .evt_len      (evt_len)
    );

    tpx_acc_queue #(
        .DEPTH (QDEPTH),
        .W     (BUF_W)
    ) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc_valid),
        .push_data (acc_buf),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .drop      (q_drop),
        .count     (q_cnt)
    );

    tpx_sequencer #(
        .ADDR_W  (ADDR_W),
        .NEVT    (NEVT),
        .DLY_W   (DLY_W),
        .GAP_W   (GAP_W),
        .BUF_W   (BUF_W),
        .FMT_TAG (FMT_TAG)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_delay    (cfg_delay),
        .cfg_gap      (cfg_gap),
        .cfg_step     (cfg_step),
        .cfg_sel      (cfg_sel),
        .cfg_sel_load (cfg_sel_load),
        .evt_start    (evt_start),
        .evt_len      (evt_len),
        .q_empty      (q_empty),
        .q_head       (q_head),
        .q_pop        (q_pop),
        .q_drop       (q_drop),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .out_full     (out_full),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .busy         (seq_busy),
        .in_gap       (seq_in_gap),
        .ovf_pending  (ovf_flag)
    );

endmodule

// File: rtl/tpx_event_tx_chk.sv
module tpx_event_tx_chk #(
    parameter int QDEPTH = 4,
    localparam int QCW   = $clog2(QDEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acc_valid,
    input logic           out_full,
    input logic           out_valid,
    input logic           q_full,
    input logic [QCW-1:0] q_cnt,
    input logic           seq_busy,
    input logic           seq_in_gap,
    input logic           ovf_flag
);

    // R10
    full_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |=> !out_valid);

    // R2
    word_inside_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(seq_busy));

    // R4
    gap_is_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_in_gap |=> !out_valid);

    // R8
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= QCW'(QDEPTH));

    // R9
    drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && q_full) |=> ovf_flag);

endmodule

bind tpx_event_tx tpx_event_tx_chk #(.QDEPTH(QDEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .out_full   (out_full),
    .out_valid  (out_valid),
    .q_full     (q_full),
    .q_cnt      (q_cnt),
    .seq_busy   (seq_busy),
    .seq_in_gap (seq_in_gap),
    .ovf_flag   (ovf_flag)
);

// File: tb/tpx_event_tx_tb_top.sv
module tpx_event_tx_tb_top;

    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [AW:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_buf = '0;
    logic        out_full = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ln     = 0;
    int rp     = 0;
    bit done   = 1'b0;
    bit stall_en  = 1'b0;
    bit full_prev = 1'b0;
    logic [31:0] lw [0:511];
    int          lc [0:511];
    logic [31:0] model [0:1023];

    always #5 clk = ~clk;

    tpx_event_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .acc_valid  (acc_valid),
        .acc_buf    (acc_buf),
        .out_full   (out_full),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    // Monitor: logs words, drives back-pressure, checks R10 each stalled cycle
    always @(negedge clk) begin
        cyc++;
        if (stall_en && full_prev) begin
            checks++;
            if (out_valid) begin
                fails++;
                $display("FAIL R10 valid after full: actual=%0b expected=0", out_valid);
            end
        end
        if (out_valid && ln < 512) begin
            lw[ln] = out_data;
            lc[ln] = cyc;
            ln++;
        end
        out_full  = stall_en && (cyc % 3 != 0);
        full_prev = out_full;
    end

    function automatic logic [31:0] pat(input int a);
        return {8'h5A, 8'(a), 16'(a * 7 + 3)};
    endfunction

    task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [AW:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic set_reg(input int idx, input logic [31:0] d);
        hw({1'b1, 10'(idx)}, d);
    endtask

    task automatic set_ev(input int e, input int start, input int len);
        set_reg(16 + e, 32'(start));
        set_reg(32 + e, 32'(len));
    endtask

    task automatic set_mode(input bit step, input int sel);
        set_reg(2, {16'h0, 8'(sel), 7'h0, step});
    endtask

    task automatic pulse(input logic [7:0] b, output int t0);
        @(negedge clk); #1;
        acc_valid = 1'b1; acc_buf = b; t0 = cyc;
        @(negedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        ln = 0; rp = 0;
    endtask

    task automatic chk_pkt(input string req, input int evt, input int b, input int len,
                           input int lat, input int start, input bit flag);
        if (rp + len + 3 > ln) begin
            checks++; fails++;
            $display("FAIL %s missing words: actual=%0d expected=%0d", req, ln - rp, len + 3);
            return;
        end
        ck({req, " hdr1"}, lw[rp], {8'hE5, 8'(evt), 8'h00, 8'(b)});
        ck({req, " hdr2"}, lw[rp + 1], {16'(lat), 16'(len)});
        for (int i = 0; i < len; i++)
            ck({req, " payload"}, lw[rp + 2 + i], model[(start + i) % 1024]);
        ck({req, " trailer"}, lw[rp + 2 + len], {16'(len), 15'b0, flag});
        rp += len + 3;
    endtask

    // R1: quiet after reset and without accepts
    task automatic t_reset();
        clear_log();
        wait_cyc(20);
        ck("R1 out_valid after reset", 32'(out_valid), 32'd0);
        ck("R1 no words without accept", 32'(ln), 32'd0);
    endtask

    // R2, R3, R12: framing and start delay
    task automatic t_frame_delay();
        int t0;
        set_reg(0, 32'd5); set_reg(1, 32'd0); set_mode(1'b0, 0);
        clear_log();
        pulse(8'h2C, t0);
        wait_cyc(40);
        ck("R3 header time delay=5", 32'(lc[0] - t0), 32'd8);
        chk_pkt("R2 frame", 0, 8'h2C, 3, 5, 10, 1'b0);
        ck("R2 word count", 32'(ln), 32'd6);
    endtask

    // R4: gap between payload words
    task automatic t_gap();
        int t0;
        set_reg(0, 32'd0); set_reg(1, 32'd3); set_mode(1'b0, 0);
        clear_log();
        pulse(8'h01, t0);
        wait_cyc(40);
        ck("R4 spacing 1", 32'(lc[3] - lc[2]), 32'd4);
        ck("R4 spacing 2", 32'(lc[4] - lc[3]), 32'd4);
        chk_pkt("R4 frame", 0, 1, 3, 0, 10, 1'b0);
        set_reg(1, 32'd0);
    endtask

    // R5: empty event, also R3 with zero delay
    task automatic t_empty();
        int t0;
        set_reg(0, 32'd0); set_mode(1'b0, 1);
        clear_log();
        pulse(8'h77, t0);
        wait_cyc(20);
        ck("R5 word count", 32'(ln), 32'd3);
        ck("R3 header time delay=0", 32'(lc[0] - t0), 32'd3);
        chk_pkt("R5 empty", 1, 8'h77, 0, 0, 0, 1'b0);
    endtask

    // R6: replay mode
    task automatic t_replay();
        int t0;
        set_mode(1'b0, 3);
        clear_log();
        pulse(8'h10, t0); wait_cyc(20);
        pulse(8'h11, t0); wait_cyc(20);
        chk_pkt("R6 first", 3, 8'h10, 2, 0, 200, 1'b0);
        chk_pkt("R6 second", 3, 8'h11, 2, 0, 200, 1'b0);
    endtask

    // R7, R11: step mode with wrap, event 2 crosses the memory end
    task automatic t_step();
        int t0;
        set_mode(1'b1, 2);
        clear_log();
        pulse(8'h20, t0); wait_cyc(20);
        pulse(8'h21, t0); wait_cyc(20);
        pulse(8'h22, t0); wait_cyc(20);
        chk_pkt("R7 R11 evt2 wrap", 2, 8'h20, 6, 0, 1020, 1'b0);
        chk_pkt("R7 evt3", 3, 8'h21, 2, 0, 200, 1'b0);
        chk_pkt("R7 evt0 wrapped", 0, 8'h22, 3, 0, 10, 1'b0);
        set_mode(1'b0, 0);
    endtask

    // R8: queued accepts in order
    task automatic t_queue();
        int t0;
        set_reg(0, 32'd0); set_mode(1'b0, 0);
        clear_log();
        pulse(8'h01, t0);
        pulse(8'h02, t0);
        pulse(8'h03, t0);
        wait_cyc(60);
        chk_pkt("R8 q1", 0, 8'h01, 3, 0, 10, 1'b0);
        chk_pkt("R8 q2", 0, 8'h02, 3, 0, 10, 1'b0);
        chk_pkt("R8 q3", 0, 8'h03, 3, 0, 10, 1'b0);
        ck("R8 total", 32'(ln), 32'd18);
    endtask

    // R9: overflow drop and flag
    task automatic t_ovf();
        int t0;
        set_reg(0, 32'd40); set_mode(1'b0, 0);
        clear_log();
        pulse(8'd10, t0);
        wait_cyc(2);
        for (int i = 11; i <= 15; i++) pulse(8'(i), t0);
        wait_cyc(400);
        ck("R9 packets kept", 32'(ln), 32'd30);
        chk_pkt("R9 flagged", 0, 10, 3, 40, 10, 1'b1);
        for (int i = 11; i <= 14; i++) chk_pkt("R9 cleared", 0, i, 3, 40, 10, 1'b0);
        set_reg(0, 32'd0);
    endtask

    // R10: back-pressure
    task automatic t_stall();
        int t0;
        set_reg(0, 32'd0); set_reg(1, 32'd0); set_mode(1'b0, 2);
        clear_log();
        stall_en = 1'b1;
        pulse(8'h40, t0);
        pulse(8'h41, t0);
        wait_cyc(120);
        stall_en = 1'b0;
        wait_cyc(4);
        ck("R10 word count", 32'(ln), 32'd18);
        chk_pkt("R10 pkt1", 2, 8'h40, 6, 0, 1020, 1'b0);
        chk_pkt("R10 pkt2", 2, 8'h41, 6, 0, 1020, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        @(negedge clk); #1 rst_n = 1'b1;
        t_reset();
        // R12: load memory through the low address space
        for (int a = 0; a < 1024; a++) begin
            model[a] = pat(a);
            hw({1'b0, 10'(a)}, pat(a));
        end
        set_ev(0, 10, 3);
        set_ev(1, 100, 0);
        set_ev(2, 1020, 6);
        set_ev(3, 200, 2);
        t_frame_delay();
        t_gap();
        t_empty();
        t_replay();
        t_step();
        t_queue();
        t_ovf();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule